// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The block collects up to 60 maskable request lines and decides which of them the processor should service next. Each line has an enable bit, a pending bit and a 4-bit priority, where a smaller number means a more urgent request. From the lines that are enabled and pending, and whose priority beats the one now running, a resolver picks a single winner. The block then opens an entry window of a fixed number of cycles. During that window it shows the winner's vector number to the core with a request strobe. At the end of the window the winner goes into service.

While the window is open, a more urgent arrival takes over the entry, so the core always enters the best candidate. A stack of running priorities lets handlers nest. A handler can be interrupted only by a request of strictly higher urgency. When a handler returns, the priority that was running before it becomes the threshold again. If a request can win against that restored threshold, the next entry starts in the cycle right after the return, with no idle cycle in between. Software sets the enables, priorities and pending bits through a single write port that carries an operation code.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `req_o` and `take_o` are low and `act_prio_o` reads 16, which means idle. Every line is disabled, not pending and at priority 0.
- R2: A line's pending bit is set in any cycle in which its `irq_i` bit is high, and also by write op 2. It is cleared by write op 3 and when the line is taken into service. A clear beats a set in the same cycle.
- R3: A line can win only if it is enabled, pending, and its priority value is strictly below `act_prio_o`. A disabled line never raises `req_o`, even while it is pending.
- R4: The winner is the eligible line with the smallest priority value. When several lines share that value, the lowest line index wins.
- R5: When a winner exists in the idle or running state, `req_o` rises in the next cycle and stays high for exactly ENTRY_CYC cycles. After that, `take_o` pulses for one cycle with `req_o` low, and `act_prio_o` shows the priority that was taken.
- R6: During the entry window, `vec_o` follows the current winner one cycle later. The line taken is the winner in the last window cycle, so a more urgent late arrival replaces the original target.
- R7: If no line is eligible during the window, `req_o` drops without a `take_o` pulse and the previous running state is kept.
- R8: A running handler is preempted only by a line whose priority value is strictly lower. Requests of equal or lower urgency wait.
- R9: A pulse on `exit_i` while a handler runs and no entry is open pops the stack, and `act_prio_o` returns to the priority that ran before (16 when none did). In any other state `exit_i` is ignored.
- R10: If a line can win against the restored threshold when a handler exits, `req_o` is high in the very next cycle (tail-chaining).
- R11: Write ops are: 0 enable, 1 disable, 2 set pending, 3 clear pending, 4 load priority from `cfg_prio`. Codes 5 to 7 and indices at or above NUM_IRQ have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Request lines, sampled on each clock |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Write operation code |
| cfg_idx | input | IDX_W | Line index addressed by the write |
| cfg_prio | input | PRIO_W | Priority value for op 4 |
| exit_i | input | 1 | Handler return pulse |
| req_o | output | 1 | Entry window open |
| vec_o | output | IDX_W | Vector of the entry target or of the taken line |
| take_o | output | 1 | One-cycle pulse when a vector goes into service |
| act_prio_o | output | PRIO_W+1 | Running priority, 16 when idle |

## Verification
The assertions assume that `irq_i`, `exit_i` and the write port are already synchronous to `clk`. They also assume ENTRY_CYC is small enough for the entry-length counter in the checker to hold it without wrapping. The stimulus drives every input on the falling edge and includes the cases the checker must tolerate: out-of-range indices, unused operation codes and return pulses while idle or during entry. A behavioural model in the bench predicts the four outputs on every clock. Directed sequences cover tie-breaking, late arrival, abort, nested preemption and tail-chaining.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   typedef enum logic [2:0] {
      OP_ENABLE  = 3'd0,
      OP_DISABLE = 3'd1,
      OP_PSET    = 3'd2,
      OP_PCLR    = 3'd3,
      OP_PRIO    = 3'd4
   } cfg_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ENTRY = 2'd1,
      ST_RUN   = 2'd2
   } ctl_st_e;

endpackage

// File: rtl/irqc_line_bank.sv
module irqc_line_bank
   import irqc_pkg::*;
#(
   parameter int NUM_IRQ = 60,
   parameter int PRIO_W  = 4,
   parameter int IDX_W   = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        irq_i,
   input  logic                      cfg_wr,
   input  logic [2:0]                cfg_op,
   input  logic [IDX_W-1:0]          cfg_idx,
   input  logic [PRIO_W-1:0]         cfg_prio,
   input  logic                      take_i,
   input  logic [IDX_W-1:0]          take_idx,
   output logic [NUM_IRQ-1:0]        en_o,
   output logic [NUM_IRQ-1:0]        pend_o,
   output logic [NUM_IRQ*PRIO_W-1:0] prio_o
);

   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      logic              hit;
      logic              set_p, clr_p;
      logic              en_q, pend_q;
      logic [PRIO_W-1:0] prio_q;

      assign hit   = cfg_wr && (cfg_idx == IDX_W'(i));
      assign set_p = irq_i[i] || (hit && cfg_op == OP_PSET);
      assign clr_p = (take_i && take_idx == IDX_W'(i)) || (hit && cfg_op == OP_PCLR);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            prio_q <= '0;
         end else begin
            if (hit && cfg_op == OP_ENABLE)  en_q <= 1'b1;
            if (hit && cfg_op == OP_DISABLE) en_q <= 1'b0;
            if (hit && cfg_op == OP_PRIO)    prio_q <= cfg_prio;
            if (clr_p)      pend_q <= 1'b0;
            else if (set_p) pend_q <= 1'b1;
         end
      end

      assign en_o[i]                   = en_q;
      assign pend_o[i]                 = pend_q;
      assign prio_o[i*PRIO_W +: PRIO_W] = prio_q;
   end

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int NUM_IRQ = 60,
   parameter int PRIO_W  = 4,
   parameter int IDX_W   = 6
) (
   input  logic [NUM_IRQ-1:0]        en_i,
   input  logic [NUM_IRQ-1:0]        pend_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
   input  logic [PRIO_W:0]           thresh_i,
   output logic                      hit_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [PRIO_W-1:0]         prio_o
);

   // Scan upward; only a strictly smaller value displaces the held
   // candidate, so equal values keep the lower index.
   always_comb begin
      hit_o  = 1'b0;
      idx_o  = '0;
      prio_o = '0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (en_i[i] && pend_i[i] &&
             ({1'b0, prio_i[i*PRIO_W +: PRIO_W]} < thresh_i) &&
             (!hit_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
            hit_o  = 1'b1;
            idx_o  = IDX_W'(i);
            prio_o = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/irqc_prio_stack.sv
module irqc_prio_stack #(
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [PRIO_W-1:0] push_prio_i,
   input  logic              pop_i,
   output logic [PRIO_W:0]   top_o,
   output logic [PRIO_W:0]   below_o
);

   localparam int DEPTH = 1 << PRIO_W;
   localparam int DW    = $clog2(DEPTH + 1);
   localparam logic [PRIO_W:0] IDLE_P = (PRIO_W+1)'(DEPTH);

   logic [PRIO_W-1:0] mem [DEPTH];
   logic [DW-1:0]     lvl;

   assign top_o   = (lvl == '0) ? IDLE_P
                                : {1'b0, mem[PRIO_W'(lvl - DW'(1))]};
   assign below_o = (lvl < DW'(2)) ? IDLE_P
                                   : {1'b0, mem[PRIO_W'(lvl - DW'(2))]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl <= '0;
      else if (push_i) lvl <= lvl + DW'(1);
      else if (pop_i)  lvl <= lvl - DW'(1);
   end

   always_ff @(posedge clk) begin
      if (push_i) mem[PRIO_W'(lvl)] <= push_prio_i;
   end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_IRQ   = 60,
   parameter int PRIO_W    = 4,
   parameter int ENTRY_CYC = 3,
   localparam int IDX_W    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               cfg_wr,
   input  logic [2:0]         cfg_op,
   input  logic [IDX_W-1:0]   cfg_idx,
   input  logic [PRIO_W-1:0]  cfg_prio,
   input  logic               exit_i,
   output logic               req_o,
   output logic [IDX_W-1:0]   vec_o,
   output logic               take_o,
   output logic [PRIO_W:0]    act_prio_o
);

   localparam int CNT_W = (ENTRY_CYC > 1) ? $clog2(ENTRY_CYC) : 1;
   localparam logic [PRIO_W:0] IDLE_P = (PRIO_W+1)'(1 << PRIO_W);

   initial begin : g_param_chk
      assert (NUM_IRQ >= 2 && NUM_IRQ <= 256)
         else $error("irq_prio_ctrl: NUM_IRQ out of range");
      assert (PRIO_W >= 1 && PRIO_W <= 6)
         else $error("irq_prio_ctrl: PRIO_W out of range");
      assert (ENTRY_CYC >= 1 && ENTRY_CYC <= 64)
         else $error("irq_prio_ctrl: ENTRY_CYC out of range");
   end

   ctl_st_e                  st;
   logic [CNT_W-1:0]         cnt;
   logic [IDX_W-1:0]         tgt_vec;
   logic                     take_q;

   logic [NUM_IRQ-1:0]        en_q, pend_q;
   logic [NUM_IRQ*PRIO_W-1:0] prio_q;
   logic [PRIO_W:0]           top_p, below_p, thresh;
   logic                      win_hit, exit_acc, do_take;
   logic [IDX_W-1:0]          win_idx;
   logic [PRIO_W-1:0]         win_prio;

   assign exit_acc = exit_i && (st == ST_RUN);
   assign thresh   = exit_acc ? below_p : top_p;
   assign do_take  = (st == ST_ENTRY) && win_hit && (cnt == '0);

   irqc_line_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_i    (irq_i),
      .cfg_wr   (cfg_wr),
      .cfg_op   (cfg_op),
      .cfg_idx  (cfg_idx),
      .cfg_prio (cfg_prio),
      .take_i   (do_take),
      .take_idx (win_idx),
      .en_o     (en_q),
      .pend_o   (pend_q),
      .prio_o   (prio_q)
   );

   irqc_pick #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
      .en_i     (en_q),
      .pend_i   (pend_q),
      .prio_i   (prio_q),
      .thresh_i (thresh),
      .hit_o    (win_hit),
      .idx_o    (win_idx),
      .prio_o   (win_prio)
   );

   irqc_prio_stack #(.PRIO_W(PRIO_W)) u_stack (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (do_take),
      .push_prio_i (win_prio),
      .pop_i       (exit_acc),
      .top_o       (top_p),
      .below_o     (below_p)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         tgt_vec <= '0;
         take_q  <= 1'b0;
      end else begin
         take_q <= do_take;
         unique case (st)
            ST_IDLE, ST_RUN: begin
               if (win_hit) begin
                  st      <= ST_ENTRY;
                  tgt_vec <= win_idx;
                  cnt     <= CNT_W'(ENTRY_CYC - 1);
               end else if (exit_acc && below_p == IDLE_P) begin
                  st <= ST_IDLE;
               end
            end
            ST_ENTRY: begin
               if (!win_hit) begin
                  st <= (top_p == IDLE_P) ? ST_IDLE : ST_RUN;
               end else begin
                  tgt_vec <= win_idx;
                  if (cnt == '0) st  <= ST_RUN;
                  else           cnt <= cnt - CNT_W'(1);
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_o      = (st == ST_ENTRY);
   assign vec_o      = tgt_vec;
   assign take_o     = take_q;
   assign act_prio_o = top_p;

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
   parameter int NUM_IRQ   = 60,
   parameter int PRIO_W    = 4,
   parameter int ENTRY_CYC = 3,
   parameter int IDX_W     = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_o,
   input logic               take_o,
   input logic [IDX_W-1:0]   vec_o,
   input logic [PRIO_W:0]    act_prio_o,
   input logic               exit_acc,
   input logic               win_hit,
   input logic [NUM_IRQ-1:0] pend_q
);

   logic [7:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 run_len <= '0;
      else if (!req_o)            run_len <= '0;
      else if (run_len != 8'hff)  run_len <= run_len + 8'd1;
   end

   AST_TAKE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (run_len == 8'(ENTRY_CYC)));                       // R5
   AST_TAKE_NOT_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !req_o);                                           // R5
   AST_STRICT_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (act_prio_o < $past(act_prio_o)));                 // R8
   AST_TAIL_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (exit_acc && win_hit) |=> req_o);                             // R10
   AST_TAKEN_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !pend_q[vec_o]);                                   // R2

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
   .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ENTRY_CYC(ENTRY_CYC), .IDX_W(IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_o      (req_o),
   .take_o     (take_o),
   .vec_o      (vec_o),
   .act_prio_o (act_prio_o),
   .exit_acc   (exit_acc),
   .win_hit    (win_hit),
   .pend_q     (pend_q)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;

   localparam int N  = 60;
   localparam int PW = 4;
   localparam int EC = 3;
   localparam int IW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_i = '0;
   logic          cfg_wr = 1'b0;
   logic [2:0]    cfg_op = '0;
   logic [IW-1:0] cfg_idx = '0;
   logic [PW-1:0] cfg_prio = '0;
   logic          exit_i = 1'b0;
   logic          req_o, take_o;
   logic [IW-1:0] vec_o;
   logic [PW:0]   act_prio_o;

   int checks = 0, failures = 0, cyc = 0;
   bit done = 0;

   irq_prio_ctrl #(.NUM_IRQ(N), .PRIO_W(PW), .ENTRY_CYC(EC)) dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cfg_wr(cfg_wr), .cfg_op(cfg_op),
      .cfg_idx(cfg_idx), .cfg_prio(cfg_prio), .exit_i(exit_i), .req_o(req_o),
      .vec_o(vec_o), .take_o(take_o), .act_prio_o(act_prio_o));

   always #2 clk = ~clk;

   // ---------------- behavioural reference ----------------
   bit m_en [N];
   bit m_pend [N];
   int m_prio [N];
   int m_stk [$];
   int m_st = 0;       // 0 idle, 1 entry, 2 running
   int m_cnt = 0, m_tgt = 0;
   bit m_take = 0;

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin m_en[i] = 0; m_pend[i] = 0; m_prio[i] = 0; end
      m_stk.delete(); m_st = 0; m_cnt = 0; m_tgt = 0; m_take = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int top, below, th, bw, bp, n;
         bit ex, tk;
         n     = m_stk.size();
         top   = (n > 0) ? m_stk[n-1] : 16;
         below = (n > 1) ? m_stk[n-2] : 16;
         ex    = exit_i && (m_st == 2);
         th    = ex ? below : top;
         bw = -1; bp = 99;
         for (int i = 0; i < N; i++)
            if (m_en[i] && m_pend[i] && m_prio[i] < th && m_prio[i] < bp) begin
               bw = i; bp = m_prio[i];
            end
         tk = (m_st == 1) && (bw >= 0) && (m_cnt == 0);
         for (int i = 0; i < N; i++) begin
            bit hit, clr, set;
            hit = cfg_wr && (int'(cfg_idx) == i);
            clr = (tk && bw == i) || (hit && cfg_op == 3);
            set = irq_i[i] || (hit && cfg_op == 2);
            if (clr) m_pend[i] = 0; else if (set) m_pend[i] = 1;
            if (hit && cfg_op == 0) m_en[i] = 1;
            if (hit && cfg_op == 1) m_en[i] = 0;
            if (hit && cfg_op == 4) m_prio[i] = int'(cfg_prio);
         end
         if (m_st == 1) begin
            if (bw < 0) m_st = (top == 16) ? 0 : 2;
            else begin
               m_tgt = bw;
               if (m_cnt == 0) m_st = 2; else m_cnt--;
            end
         end else if (bw >= 0) begin
            m_st = 1; m_tgt = bw; m_cnt = EC - 1;
         end else if (ex && below == 16) m_st = 0;
         if (tk) m_stk.push_back(bp);
         if (ex) void'(m_stk.pop_back());
         m_take = tk;
      end
   end

   task automatic chk(string r, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", r, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int n;
         n = m_stk.size();
         chk("R5", "req_o", int'(req_o), int'(m_st == 1));
         chk("R5", "take_o", int'(take_o), int'(m_take));
         chk("R9", "act_prio_o", int'(act_prio_o), (n > 0) ? m_stk[n-1] : 16);
         if (m_st == 1 || m_take) chk("R6", "vec_o", int'(vec_o), m_tgt);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(int op, int idx, int pr);
      @(negedge clk);
      cfg_wr = 1; cfg_op = 3'(op); cfg_idx = IW'(idx); cfg_prio = PW'(pr);
      @(negedge clk);
      cfg_wr = 0;
   endtask

   task automatic pulse_irq(int a, int b);
      @(negedge clk);
      irq_i[a] = 1; irq_i[b] = 1;
      @(negedge clk);
      irq_i = '0;
   endtask

   task automatic wait_take(output bit got);
      got = 0;
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (take_o) begin got = 1; break; end
      end
   endtask

   task automatic wait_req();
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (req_o) break;
      end
   endtask

   task automatic quiet(string r, int cycles);
      bit seen;
      seen = 0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (req_o || take_o) seen = 1;
      end
      chk(r, "no request activity", int'(seen), 0);
   endtask

   task automatic do_exit();
      exit_i = 1;
      @(negedge clk);
      exit_i = 0;
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- sequence ----------------
   initial begin
      bit got;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "req_o", int'(req_o), 0);
      chk("R1", "take_o", int'(take_o), 0);
      chk("R1", "act_prio_o", int'(act_prio_o), 16);
      quiet("R1", 3);

      // R11 configuration ops, out-of-range index and unused codes
      wr(0, 5, 0); wr(0, 9, 0); wr(0, 20, 0);
      wr(4, 5, 3); wr(4, 9, 3); wr(4, 20, 1);
      wr(0, 63, 0); wr(2, 63, 0); wr(5, 9, 0); wr(7, 5, 0);
      quiet("R11", 6);

      // R3 a disabled line that is pending stays silent
      pulse_irq(30, 30);
      quiet("R3", 6);
      // R2 software clear removes the pending state before enabling
      wr(3, 30, 0); wr(0, 30, 0);
      quiet("R2", 6);
      pulse_irq(30, 30);
      wait_take(got);
      chk("R2", "take seen line 30", int'(got), 1);
      chk("R1", "default priority of line 30", int'(act_prio_o), 0);
      do_exit();
      chk("R9", "act after exit", int'(act_prio_o), 16);
      wr(1, 30, 0);

      // R4 tie at priority 3 resolved to lower index
      pulse_irq(5, 9);
      wait_take(got);
      chk("R4", "vec on tie", int'(vec_o), 5);
      chk("R5", "act prio", int'(act_prio_o), 3);
      // R8 equal priority does not preempt
      quiet("R8", 6);
      // R10 tail chain to line 9 on exit
      exit_i = 1;
      @(negedge clk);
      exit_i = 0;
      chk("R10", "req right after exit", int'(req_o), 1);
      chk("R10", "tail vec", int'(vec_o), 9);
      wait_take(got);
      chk("R5", "take line 9", int'(got), 1);
      do_exit();
      chk("R9", "idle after exit", int'(act_prio_o), 16);
      chk("R9", "no req", int'(req_o), 0);

      // R6 late arrival of line 20 during entry to line 5
      pulse_irq(5, 5);
      wait_req();
      chk("R6", "initial target", int'(vec_o), 5);
      irq_i[20] = 1;
      @(negedge clk);
      irq_i = '0;
      wait_take(got);
      chk("R6", "late winner vec", int'(vec_o), 20);
      chk("R6", "late winner prio", int'(act_prio_o), 1);
      exit_i = 1;
      @(negedge clk);
      exit_i = 0;
      chk("R10", "tail chain to 5", int'(req_o), 1);
      wait_take(got);
      chk("R10", "taken 5", int'(vec_o), 5);

      // R8 strictly higher preempts, R9 nested restore
      pulse_irq(20, 20);
      wait_take(got);
      chk("R8", "preempting vec", int'(vec_o), 20);
      chk("R8", "nested prio", int'(act_prio_o), 1);
      do_exit();
      chk("R9", "restored prio", int'(act_prio_o), 3);
      do_exit();
      chk("R9", "back to idle", int'(act_prio_o), 16);

      // R9 exit ignored while idle
      do_exit();
      chk("R9", "exit idle ignored", int'(act_prio_o), 16);

      // R7 abort when the target's pending bit is cleared
      wr(2, 9, 0);
      wait_req();
      chk("R7", "entry opened", int'(req_o), 1);
      cfg_wr = 1; cfg_op = 3'd3; cfg_idx = 6'd9;
      @(negedge clk);
      cfg_wr = 0;
      quiet("R7", 1);
      quiet("R7", 4);
      chk("R7", "act kept idle", int'(act_prio_o), 16);

      // random phase with reference comparison each cycle
      for (int i = 0; i < N; i += 2) wr(0, i, i % 16);
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         irq_i  = '0;
         if ($urandom_range(3) == 0) irq_i[$urandom_range(N-1)] = 1;
         cfg_wr = ($urandom_range(7) == 0);
         cfg_op = 3'($urandom_range(7));
         cfg_idx = IW'($urandom_range(63));
         cfg_prio = PW'($urandom_range(15));
         exit_i = ($urandom_range(3) == 0);
      end
      @(negedge clk);
      irq_i = '0; cfg_wr = 0; exit_i = 0;
      repeat (5) @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule